// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Core

This core keeps wall-clock time for a system whose host writes and reads it through a small parallel register port. A slow tick enable, nominally 32768 pulses per second, drives a sub-second counter. Each time that counter completes a second, a set of BCD calendar counters advances: seconds, minutes, hours, day of month, month, year within 2000 to 2099, and weekday. Rollover follows month lengths and leap years.

The host stops the clock to load a new time and then restarts it. To read the time, the host raises a snapshot control bit. That rising edge freezes a coherent copy of every field, and the time addresses always return this copy. A six-field alarm raises a sticky flag when the live time matches it, and an interrupt output follows that flag through an enable bit. A signed 16-bit trim value can be applied once per hour to correct crystal drift. It is loaded into the sub-second counter on the second that begins as the seconds count leaves 0 at minute 0.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the clock is stopped, the run control bit (0x10 bit 0) is 0, and the time and snapshot fields read 2000-01-01 00:00:00 with weekday 0. Addresses 0x00 to 0x06 read seconds, minutes, hours, day, month (1 to 12), year (00 to 99) and weekday (0 to 6), each as two BCD digits.
- R2: While the clock runs, the time advances by one second after every TICKS_PER_SEC tick enables. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00, each carrying into the next field.
- R3: Day rollover follows the month length: 30 for April, June, September and November, 31 for the other months, and 29 for February when the year is divisible by 4, else 28. December 31 rolls to January 1 of the next year, and year 99 wraps to 00. The weekday advances with the day and wraps from 6 to 0.
- R4: When run is 0, counting halts and writes to 0x00 to 0x06 load the time. Writes to those addresses while run is 1 are ignored.
- R5: The running output and status bit 0 (0x11) equal the run control bit and are 0 whenever the clock is stopped.
- R6: A write to 0x10 that takes bit 1 from 0 to 1 copies the live time into the snapshot. The time addresses return the snapshot, and it does not change while bit 1 stays 1.
- R7: Alarm fields at 0x08 to 0x0D hold seconds, minutes, hours, day, month and year in BCD. When the time reached by a second step equals all six fields, status bit 1 (0x11) is set. It stays set until a write to 0x11 with bit 1 set clears it, and a new match in the same cycle wins over the clear.
- R8: alarm_irq is high exactly when the alarm flag is set and the enable at 0x12 bit 0 is 1.
- R9: The trim value is written at 0x14 (low byte) and 0x15 (high byte) in two's complement, and is enabled by 0x10 bit 2. When enabled, at the second step from seconds 0 to 1 with minutes 0, the sub-second count starts at the trim value instead of 0, capped at TICKS_PER_SEC-1. That second therefore lasts TICKS_PER_SEC minus the trim value in ticks, and at least one tick. When disabled, no trim is applied.
- R10: The sub-second count is held at 0 while stopped, so the first second after a start lasts a full TICKS_PER_SEC ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-second tick enable, one pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| alarm_irq | output | 1 | Alarm interrupt, flag AND enable |
| running | output | 1 | High while the counters are allowed to advance |

## Verification
The hardest case to reach is the hourly trim, because it needs the time at minute 0 crossing from second 0 to 1 with trim enabled. Reaching it from reset would take an hour of ticks. The stimulus instead stops the clock, loads 07:59:58, sets a small ticks-per-second parameter, and takes repeated snapshots across the boundary with positive, negative, capped and disabled trim values. Calendar edges are reached the same way, by loading the last second of a leap February, a common February, a 30-day month and the last day of year 99. Tick enables are also randomized for part of the run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] wday;
    } rtc_time_t;

    localparam int NUM_TIME  = 7;
    localparam int NUM_ALARM = 6;
    localparam int A_TIME    = 0;
    localparam int A_ALARM   = 8;
    localparam int A_CTRL    = 16;
    localparam int A_STAT    = 17;
    localparam int A_IEN     = 18;
    localparam int A_COMP_LO = 20;
    localparam int A_COMP_HI = 21;

    localparam rtc_time_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         day: 8'h01, mon: 8'h01, year: 8'h00,
                                         wday: 8'h00};

    function automatic logic [6:0] bcd2bin(logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin2bcd(logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [6:0] month_days(logic [6:0] mon, logic [6:0] yr);
        case (mon)
            7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

    function automatic logic [7:0] get_field(rtc_time_t t, int idx);
        case (idx)
            0:       return t.sec;
            1:       return t.min;
            2:       return t.hour;
            3:       return t.day;
            4:       return t.mon;
            5:       return t.year;
            default: return t.wday;
        endcase
    endfunction

    function automatic rtc_time_t put_field(rtc_time_t t, int idx, logic [7:0] v);
        rtc_time_t r;
        r = t;
        case (idx)
            0:       r.sec  = v;
            1:       r.min  = v;
            2:       r.hour = v;
            3:       r.day  = v;
            4:       r.mon  = v;
            5:       r.year = v;
            default: r.wday = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    always_comb begin
        logic [6:0] s, m, h, d, mo, y, w;
        s  = bcd2bin(cur.sec);
        m  = bcd2bin(cur.min);
        h  = bcd2bin(cur.hour);
        d  = bcd2bin(cur.day);
        mo = bcd2bin(cur.mon);
        y  = bcd2bin(cur.year);
        w  = bcd2bin(cur.wday);
        if (s != 7'd59) begin
            s = s + 7'd1;
        end else begin
            s = '0;
            if (m != 7'd59) begin
                m = m + 7'd1;
            end else begin
                m = '0;
                if (h != 7'd23) begin
                    h = h + 7'd1;
                end else begin
                    h = '0;
                    w = (w == 7'd6) ? 7'd0 : w + 7'd1;
                    if (d < month_days(mo, y)) begin
                        d = d + 7'd1;
                    end else begin
                        d = 7'd1;
                        if (mo != 7'd12) begin
                            mo = mo + 7'd1;
                        end else begin
                            mo = 7'd1;
                            y  = (y == 7'd99) ? 7'd0 : y + 7'd1;
                        end
                    end
                end
            end
        end
        nxt.sec  = bin2bcd(s);
        nxt.min  = bin2bcd(m);
        nxt.hour = bin2bcd(h);
        nxt.day  = bin2bcd(d);
        nxt.mon  = bin2bcd(mo);
        nxt.year = bin2bcd(y);
        nxt.wday = bin2bcd(w);
    end

endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        run,
    input  logic        comp_apply,
    input  logic [15:0] comp,
    output logic        sec_step
);

    localparam int SW = $clog2(TICKS_PER_SEC) + 18;
    localparam logic signed [SW-1:0] TOP = SW'(TICKS_PER_SEC - 1);
    localparam logic signed [SW-1:0] ONE = SW'(1);

    logic signed [SW-1:0] sub_q, sub_d;
    logic signed [SW-1:0] comp_ext;

    assign comp_ext = {{(SW-16){comp[15]}}, comp};
    assign sec_step = tick_en && run && (sub_q >= TOP);

    always_comb begin
        sub_d = sub_q;
        if (!run) begin
            sub_d = '0;
        end else if (tick_en) begin
            if (sub_q >= TOP)
                sub_d = comp_apply ? ((comp_ext > TOP) ? TOP : comp_ext) : '0;
            else
                sub_d = sub_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end

    // R9: a trimmed start never lies beyond the step threshold
    a_r9_sub_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= TOP);

    // R10: a stopped clock leaves the count at zero for the restart
    a_r10_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sub_q == '0) || run);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int AW            = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          alarm_irq,
    output logic          running
);

    typedef struct packed {
        rtc_time_t   tm;
        rtc_time_t   shadow;
        rtc_time_t   alarm;
        logic        run;
        logic        snap;
        logic        comp_en;
        logic        aflag;
        logic        ien;
        logic [15:0] comp;
    } core_regs_t;

    core_regs_t r_q, r_d;
    rtc_time_t  stepped;
    logic       sec_step;
    logic       comp_apply;

    assign comp_apply = r_q.comp_en && (r_q.tm.sec == 8'h00) && (r_q.tm.min == 8'h00);

    rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .run        (r_q.run),
        .comp_apply (comp_apply),
        .comp       (r_q.comp),
        .sec_step   (sec_step)
    );

    rtc_cal_step u_step (
        .cur (r_q.tm),
        .nxt (stepped)
    );

    always_comb begin
        logic hit;
        r_d = r_q;
        hit = 1'b0;
        if (sec_step) begin
            r_d.tm = stepped;
            hit = {stepped.sec, stepped.min, stepped.hour, stepped.day, stepped.mon, stepped.year}
               == {r_q.alarm.sec, r_q.alarm.min, r_q.alarm.hour, r_q.alarm.day, r_q.alarm.mon, r_q.alarm.year};
        end
        if (wr_en) begin
            for (int i = 0; i < NUM_TIME; i++)
                if (addr == AW'(A_TIME + i) && !r_q.run)
                    r_d.tm = put_field(r_d.tm, i, wdata);
            for (int i = 0; i < NUM_ALARM; i++)
                if (addr == AW'(A_ALARM + i))
                    r_d.alarm = put_field(r_d.alarm, i, wdata);
            if (addr == AW'(A_CTRL)) begin
                r_d.run     = wdata[0];
                r_d.snap    = wdata[1];
                r_d.comp_en = wdata[2];
                if (wdata[1] && !r_q.snap)
                    r_d.shadow = r_q.tm;
            end
            if (addr == AW'(A_STAT) && wdata[1])
                r_d.aflag = 1'b0;
            if (addr == AW'(A_IEN))
                r_d.ien = wdata[0];
            if (addr == AW'(A_COMP_LO))
                r_d.comp[7:0] = wdata;
            if (addr == AW'(A_COMP_HI))
                r_d.comp[15:8] = wdata;
        end
        if (hit)
            r_d.aflag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.tm     <= RESET_TIME;
            r_q.shadow <= RESET_TIME;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TIME; i++)
            if (addr == AW'(A_TIME + i))
                rdata = get_field(r_q.shadow, i);
        for (int i = 0; i < NUM_ALARM; i++)
            if (addr == AW'(A_ALARM + i))
                rdata = get_field(r_q.alarm, i);
        if (addr == AW'(A_CTRL))    rdata = {5'b0, r_q.comp_en, r_q.snap, r_q.run};
        if (addr == AW'(A_STAT))    rdata = {6'b0, r_q.aflag, r_q.run};
        if (addr == AW'(A_IEN))     rdata = {7'b0, r_q.ien};
        if (addr == AW'(A_COMP_LO)) rdata = r_q.comp[7:0];
        if (addr == AW'(A_COMP_HI)) rdata = r_q.comp[15:8];
    end

    assign running   = r_q.run;
    assign alarm_irq = r_q.aflag && r_q.ien;

    // R1: every completed second changes the live time
    a_r1_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        sec_step |=> r_q.tm != $past(r_q.tm));

    // R2: seconds stay valid BCD below 60
    a_r2_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tm.sec[3:0] <= 4'd9) && (r_q.tm.sec <= 8'h59));

    // R3: month stays 1-based
    a_r3_month_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tm.mon >= 8'h01) && (r_q.tm.mon <= 8'h12));

    // R4: stopped clock with no write keeps its time
    a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.run && !wr_en) |=> $stable(r_q.tm));

    // R6: snapshot only moves on a rising snapshot bit
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(A_CTRL) && wdata[1] && !r_q.snap) |=> $stable(r_q.shadow));

    // R7: flag persists until a clearing write
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.aflag && !(wr_en && addr == AW'(A_STAT) && wdata[1])) |=> r_q.aflag);

endmodule

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
    localparam int T  = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    wire  [7:0]    rdata;
    wire           alarm_irq;
    wire           running;

    int  checks = 0;
    int  errors = 0;
    bit  rand_tick = 0;
    bit  done = 0;

    int          m_t[7];
    int          m_sh[7];
    int          m_al[6];
    int          m_sub;
    bit          m_run, m_snap, m_cen, m_flag, m_ien;
    logic [15:0] m_comp;

    rtc_calendar_core #(.TICKS_PER_SEC(T), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_irq(alarm_irq), .running(running)
    );

    always #2.5 clk = ~clk;

    function automatic int to_bcd(int v); return (v / 10) * 16 + v % 10; endfunction
    function automatic int from_bcd(int b); return (b / 16) * 10 + b % 16; endfunction
    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_reset();
        m_t  = '{0, 0, 0, 1, 1, 0, 0};
        m_sh = '{0, 0, 0, 1, 1, 0, 0};
        m_al = '{0, 0, 0, 0, 0, 0};
        m_sub = 0; m_run = 0; m_snap = 0; m_cen = 0; m_flag = 0; m_ien = 0; m_comp = '0;
    endtask

    task automatic m_step();
        m_t[0]++;
        if (m_t[0] == 60) begin
            m_t[0] = 0; m_t[1]++;
            if (m_t[1] == 60) begin
                m_t[1] = 0; m_t[2]++;
                if (m_t[2] == 24) begin
                    m_t[2] = 0;
                    m_t[6] = (m_t[6] + 1) % 7;
                    m_t[3]++;
                    if (m_t[3] > mdays(m_t[4], m_t[5])) begin
                        m_t[3] = 1; m_t[4]++;
                        if (m_t[4] == 13) begin m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100; end
                    end
                end
            end
        end
    endtask

    // behavioural reference, advanced on the same edges as the design
    always @(posedge clk) begin
        int ot[7];
        bit orun, osnap, ocen, hit;
        logic [15:0] ocomp;
        int c;
        if (!rst_n) begin
            m_reset();
        end else begin
            ot = m_t; orun = m_run; osnap = m_snap; ocen = m_cen; ocomp = m_comp; hit = 0;
            if (!orun) begin
                m_sub = 0;
            end else if (tick_en) begin
                if (m_sub >= T - 1) begin
                    if (ocen && ot[0] == 0 && ot[1] == 0) begin
                        c = int'($signed(ocomp));
                        m_sub = (c > T - 1) ? T - 1 : c;
                    end else begin
                        m_sub = 0;
                    end
                    m_step();
                    hit = 1;
                    for (int i = 0; i < 6; i++) if (m_t[i] != m_al[i]) hit = 0;
                end else begin
                    m_sub++;
                end
            end
            if (wr_en) begin
                if (addr < 7 && !orun) m_t[addr] = from_bcd(int'(wdata));
                if (addr >= 8 && addr < 14) m_al[addr-8] = from_bcd(int'(wdata));
                if (addr == 16) begin
                    if (wdata[1] && !osnap) m_sh = ot;
                    m_run = wdata[0]; m_snap = wdata[1]; m_cen = wdata[2];
                end
                if (addr == 17 && wdata[1]) m_flag = 0;
                if (addr == 18) m_ien = wdata[0];
                if (addr == 20) m_comp[7:0] = wdata;
                if (addr == 21) m_comp[15:8] = wdata;
            end
            if (hit) m_flag = 1;
        end
    end

    function automatic int exp_rd(int a);
        if (a < 7) return to_bcd(m_sh[a]);
        if (a >= 8 && a < 14) return to_bcd(m_al[a-8]);
        if (a == 16) return {m_cen, m_snap, m_run};
        if (a == 17) return {m_flag, m_run};
        if (a == 18) return int'(m_ien);
        if (a == 20) return int'(m_comp[7:0]);
        if (a == 21) return int'(m_comp[15:8]);
        return 0;
    endfunction

    always @(negedge clk) begin
        tick_en <= rand_tick ? 1'($urandom % 2) : 1'b1;
        if (rst_n && !done) begin
            chk("R5 running", int'(running), int'(m_run));
            chk("R8 irq", int'(alarm_irq), int'(m_flag && m_ien));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); addr = AW'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(int a, string req);
        @(negedge clk); addr = AW'(a); #0.5;
        chk(req, int'(rdata), exp_rd(a));
    endtask

    task automatic lit(int a, int exp, string req);
        @(negedge clk); addr = AW'(a); #0.5;
        chk(req, int'(rdata), exp);
    endtask

    task automatic snap(string req, bit all);
        int base;
        base = (m_cen ? 4 : 0) | (m_run ? 1 : 0);
        wr(16, base);
        wr(16, base | 2);
        if (all) for (int i = 0; i < 7; i++) rd(i, req);
        else rd(0, req);
    endtask

    task automatic set_time(int y, int mo, int d, int h, int mi, int s, int w);
        wr(16, 0);
        wr(0, to_bcd(s)); wr(1, to_bcd(mi)); wr(2, to_bcd(h));
        wr(3, to_bcd(d)); wr(4, to_bcd(mo)); wr(5, to_bcd(y)); wr(6, to_bcd(w));
    endtask

    task automatic trim_run(int cval, bit en, string req);
        set_time(10, 5, 5, 7, 59, 58, 3);
        wr(20, cval & 255); wr(21, (cval >> 8) & 255);
        wr(16, en ? 5 : 1);
        for (int k = 0; k < 30; k++) snap(req, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        lit(0, 8'h00, "R1 sec"); lit(1, 8'h00, "R1 min"); lit(2, 8'h00, "R1 hour");
        lit(3, 8'h01, "R1 day"); lit(4, 8'h01, "R1 mon"); lit(5, 8'h00, "R1 year");
        lit(6, 8'h00, "R1 wday"); lit(16, 0, "R1 ctrl"); lit(17, 0, "R5 status stopped");

        // R2/R3: leap February end
        set_time(4, 2, 28, 23, 59, 58, 6);
        wr(16, 1);
        repeat (12) @(negedge clk);
        snap("R2 running snapshot", 1);
        wr(16, 0);
        snap("R3 leap", 1);
        lit(3, 8'h29, "R3 leap day"); lit(4, 8'h02, "R3 leap mon"); lit(6, 8'h00, "R3 wday wrap");

        // R3: common February
        set_time(1, 2, 28, 23, 59, 59, 3);
        wr(16, 1); repeat (8) @(negedge clk); wr(16, 0);
        snap("R3 common feb", 1);
        lit(3, 8'h01, "R3 mar day"); lit(4, 8'h03, "R3 mar mon"); lit(6, 8'h04, "R3 wday");

        // R3: 30-day month and century wrap
        set_time(10, 4, 30, 23, 59, 59, 1);
        wr(16, 1); repeat (6) @(negedge clk); wr(16, 0);
        snap("R3 april", 1); lit(4, 8'h05, "R3 may");
        set_time(99, 12, 31, 23, 59, 59, 5);
        wr(16, 1); repeat (6) @(negedge clk); wr(16, 0);
        snap("R3 year wrap", 1);
        lit(5, 8'h00, "R3 year 00"); lit(4, 8'h01, "R3 jan"); lit(3, 8'h01, "R3 day 1");

        // R4: write while running ignored
        set_time(10, 6, 1, 12, 34, 10, 2);
        wr(16, 1);
        wr(0, 8'h45);
        repeat (5) @(negedge clk);
        wr(16, 0);
        snap("R4 ignored write", 1);
        @(negedge clk); addr = AW'(0); #0.5;
        chk("R4 sec not loaded", int'(rdata == 8'h45), 0);

        // R6: snapshot held while bit stays high
        wr(16, 1); wr(16, 3);
        repeat (20) @(negedge clk);
        wr(16, 3);
        for (int i = 0; i < 7; i++) rd(i, "R6 held snapshot");
        wr(16, 1);

        // R10: stop mid-second and restart
        repeat (2) @(negedge clk); wr(16, 0); wr(16, 1);
        for (int k = 0; k < 6; k++) snap("R10 full first second", 0);

        // R7/R8: alarm
        set_time(10, 5, 5, 10, 20, 30, 3);
        wr(8, 8'h33); wr(9, 8'h20); wr(10, 8'h10); wr(11, 8'h05); wr(12, 8'h05); wr(13, 8'h10);
        for (int i = 8; i < 14; i++) rd(i, "R7 alarm regs");
        wr(18, 1);
        wr(16, 1);
        repeat (24) @(negedge clk);
        lit(17, 8'h03, "R7 flag set");
        wr(17, 0);
        lit(17, 8'h03, "R7 flag sticky");
        chk("R8 irq high", int'(alarm_irq), 1);
        wr(18, 0);
        @(negedge clk); chk("R8 irq masked", int'(alarm_irq), 0);
        wr(18, 1);
        @(negedge clk); chk("R8 irq restored", int'(alarm_irq), 1);
        wr(17, 2);
        lit(17, 8'h01, "R7 flag cleared");

        // R9: hourly trim
        trim_run(2, 1, "R9 positive trim");
        rd(20, "R9 comp lo"); rd(21, "R9 comp hi");
        trim_run(-5, 1, "R9 negative trim");
        trim_run(100, 1, "R9 capped trim");
        trim_run(-5, 0, "R9 trim disabled");
        rand_tick = 1;
        trim_run(-3, 1, "R9 sparse ticks");
        set_time(12, 2, 28, 23, 59, 57, 2);
        wr(16, 1);
        for (int k = 0; k < 10; k++) snap("R2 sparse ticks", 1);
        rand_tick = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule